// File: doc/BRIEF.md
# NAND Flash Bus Cycle Sequencer

This block turns simple host register writes into correctly timed bus cycles for an 8-bit NAND flash device. The host selects one of four ports: configuration, command, address or data. A write to the command port produces a single byte cycle with the command latch strobe raised. A write to the address port produces one with the address latch strobe raised. A data write sends one byte, or a full 32-bit word as four byte cycles with the low byte first. A data read request runs one or four read-strobe cycles and returns the assembled result with a one-cycle valid pulse.

Every byte cycle has three phases, each programmed in the configuration register as a clock count minus one. The setup phase presents the latch strobes and the write data. In the strobe phase the write or read strobe is held low. In the hold phase the strobe is back high while the latch strobes and data stay stable. The setup field is 2 bits wide (up to 4 cycles) or 3 bits wide (up to 8 cycles), selected by the `LONG_SETUP` parameter. One configuration bit drives the active-low chip enable. The device ready/busy pin is synchronised into a status output. The host sees `host_busy` while a cycle runs and must hold its request until `host_busy` is low.

Top module: `nand_cycle_seq`

## Requirements
- R1: After reset, `cfg_q` reads hold=7, strobe=7, setup=its field maximum and chip-enable-off=1, which is 16'h8377 with the default 2-bit setup field. `nand_ce_n`, `nand_we_n` and `nand_re_n` are high, `host_busy` is low and `nand_dq_oe` is low.
- R2: The configuration layout is hold length-1 in bits [2:0], strobe length-1 in bits [6:4], setup length-1 in bits [8+SW-1:8] and chip-enable-off in bit 15, where SW is 2 (LONG_SETUP=0) or 3. A configuration write takes effect on the next cycle and reads back through `cfg_q`. All other bits read 0.
- R3: Each byte cycle is S+1 cycles with the strobe high, then T+1 cycles with the strobe low, then H+1 cycles with the strobe high. Here S, T and H are the stored field values. `host_busy` lasts exactly the sum of these cycles over all bytes of the transfer.
- R4: Host port select 2'b01 (command) runs one byte cycle with `nand_cle` high and `nand_ale` low for the whole cycle. Select 2'b10 (address) does the same with `nand_ale` high and `nand_cle` low. Both put `host_wdata[7:0]` on `nand_dq_o`. `host_word` is ignored on these ports.
- R5: Host port select 2'b11 with `host_wr` is a data write. With `host_word`=1 it sends four byte cycles carrying bits [7:0], [15:8], [23:16] and [31:24] in that order. With `host_word`=0 it sends one cycle carrying bits [7:0]. CLE and ALE stay low.
- R6: Host port select 2'b11 with `host_rd` (and `host_wr` low) pulses `nand_re_n` instead of `nand_we_n`. The byte on `nand_dq_i` is taken in the last strobe-low cycle. Word reads fill `rd_data` from the low byte up, and byte reads zero the upper 24 bits. `rd_valid` is high for one cycle, the first cycle with `host_busy` low.
- R7: `nand_ce_n` equals configuration bit 15. A value of 1 deasserts the device.
- R8: Requests made while `host_busy` is high, including configuration writes, are ignored. They start no cycle and leave `cfg_q` unchanged.
- R9: `dev_ready` equals the `nand_rb` level of two clock edges earlier (1 = ready, 0 = busy).
- R10: `nand_we_n` and `nand_re_n` are never low together, and `nand_cle` and `nand_ale` are never high together.
- R11: `nand_dq_oe` is high for every cycle of a write, command or address transfer, and low during read transfers and when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write request |
| host_rd | input | 1 | Host data read request |
| host_sel | input | 2 | Port: 0 config, 1 command, 2 address, 3 data |
| host_word | input | 1 | Data transfer is a 32-bit word (four bytes) |
| host_wdata | input | 32 | Write data |
| host_busy | output | 1 | A bus cycle is in progress; requests are ignored |
| rd_valid | output | 1 | One-cycle pulse: `rd_data` holds a finished read |
| rd_data | output | 32 | Read result |
| cfg_q | output | 16 | Configuration register readback |
| dev_ready | output | 1 | Synchronised device ready status |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_o | output | 8 | Data bus out |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_i | input | 8 | Data bus in |
| nand_rb | input | 1 | Device ready/busy pin |

## Verification
On every cycle the assertions check the following. The two strobes never overlap, and the two latch strobes never overlap. A write strobe ends inside a busy transfer. The output driver is off while reading. A stalled configuration write leaves the register unchanged. `rd_valid` never lasts two cycles. `dev_ready` only changes toward the pin level of two edges before. The per-cycle phase lengths, the byte order of word transfers, the read data assembly and the reset values depend on the programmed timing and the data, so only the bench's scenarios show them. The bench compares every busy cycle against an arithmetic model across all setup, strobe and hold combinations.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_HOLD   = 2'd3
  } phase_e;

  localparam logic [1:0] SEL_CFG  = 2'd0;
  localparam logic [1:0] SEL_CMD  = 2'd1;
  localparam logic [1:0] SEL_ADDR = 2'd2;
  localparam logic [1:0] SEL_DATA = 2'd3;

  localparam int PHASE_CNT_W = 3;
endpackage

// File: rtl/nand_cfg_reg.sv
module nand_cfg_reg #(
  parameter int SETUP_W = 2,
  parameter int CFG_W   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [SETUP_W-1:0] wr_setup,
  input  logic [2:0]         wr_strobe,
  input  logic [2:0]         wr_hold,
  input  logic               wr_ce_off,
  output logic [SETUP_W-1:0] setup_len,
  output logic [2:0]         strobe_len,
  output logic [2:0]         hold_len,
  output logic               ce_off,
  output logic [CFG_W-1:0]   cfg_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      setup_len  <= '1;
      strobe_len <= 3'd7;
      hold_len   <= 3'd7;
      ce_off     <= 1'b1;
    end else if (wr_en) begin
      setup_len  <= wr_setup;
      strobe_len <= wr_strobe;
      hold_len   <= wr_hold;
      ce_off     <= wr_ce_off;
    end
  end

  always_comb begin
    cfg_q             = '0;
    cfg_q[2:0]        = hold_len;
    cfg_q[6:4]        = strobe_len;
    cfg_q[8 +: SETUP_W] = setup_len;
    cfg_q[CFG_W-1]    = ce_off;
  end
endmodule

// File: rtl/nand_rb_sync.sv
module nand_rb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rb_pin,
  output logic ready
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], rb_pin};
  end

  assign ready = chain[STAGES-1];

  // R9
  rb_sync_chk: assert property (@(posedge clk) disable iff (rst)
    (ready != $past(ready)) |-> (ready == $past(rb_pin, 2)));
endmodule

// File: rtl/nand_phase_seq.sv
module nand_phase_seq
  import nand_seq_pkg::*;
#(
  parameter int SETUP_W = 2,
  parameter int LANES   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               multi_in,
  input  logic [SETUP_W-1:0] setup_len,
  input  logic [2:0]         strobe_len,
  input  logic [2:0]         hold_len,
  output phase_e             phase,
  output logic [$clog2(LANES)-1:0] lane,
  output logic               strobe_last,
  output logic               xfer_done
);
  localparam int LANE_W = $clog2(LANES);
  localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(LANES - 1);

  logic [PHASE_CNT_W-1:0] cnt;
  logic                   multi;
  logic                   setup_end, strobe_end, hold_end, more;

  assign setup_end  = (cnt == PHASE_CNT_W'(setup_len));
  assign strobe_end = (cnt == strobe_len);
  assign hold_end   = (cnt == hold_len);
  assign more       = multi && (lane != LAST_LANE);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      lane  <= '0;
      multi <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE: if (start) begin
          phase <= PH_SETUP;
          cnt   <= '0;
          lane  <= '0;
          multi <= multi_in;
        end
        PH_SETUP: begin
          cnt <= setup_end ? '0 : cnt + 1'b1;
          if (setup_end) phase <= PH_STROBE;
        end
        PH_STROBE: begin
          cnt <= strobe_end ? '0 : cnt + 1'b1;
          if (strobe_end) phase <= PH_HOLD;
        end
        PH_HOLD: begin
          cnt <= hold_end ? '0 : cnt + 1'b1;
          if (hold_end) begin
            if (more) begin
              phase <= PH_SETUP;
              lane  <= lane + 1'b1;
            end else begin
              phase <= PH_IDLE;
            end
          end
        end
      endcase
    end
  end

  assign strobe_last = (phase == PH_STROBE) && strobe_end;
  assign xfer_done   = (phase == PH_HOLD) && hold_end && !more;
endmodule

// File: rtl/nand_cycle_seq.sv
module nand_cycle_seq
  import nand_seq_pkg::*;
#(
  parameter bit LONG_SETUP = 1'b0,
  parameter int DATA_W     = 32,
  parameter int BYTE_W     = 8,
  parameter int CFG_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [1:0]        host_sel,
  input  logic              host_word,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_busy,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [CFG_W-1:0]  cfg_q,
  output logic              dev_ready,
  output logic              nand_ce_n,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic              nand_we_n,
  output logic              nand_re_n,
  output logic [BYTE_W-1:0] nand_dq_o,
  output logic              nand_dq_oe,
  input  logic [BYTE_W-1:0] nand_dq_i,
  input  logic              nand_rb
);
  localparam int SETUP_W = LONG_SETUP ? 3 : 2;
  localparam int LANES   = DATA_W / BYTE_W;
  localparam int LANE_W  = $clog2(LANES);

  logic [SETUP_W-1:0] setup_len;
  logic [2:0]         strobe_len, hold_len;
  logic               ce_off;
  phase_e             phase;
  logic [LANE_W-1:0]  lane;
  logic               strobe_last, xfer_done;

  logic               idle, cfg_wr, op_wr, op_rd, start, start_word;
  logic [1:0]         op_sel;
  logic               op_read;
  logic [DATA_W-1:0]  op_data, rd_buf;

  assign idle       = (phase == PH_IDLE);
  assign cfg_wr     = idle && host_wr && (host_sel == SEL_CFG);
  assign op_wr      = idle && host_wr && (host_sel != SEL_CFG);
  assign op_rd      = idle && !host_wr && host_rd && (host_sel == SEL_DATA);
  assign start      = op_wr || op_rd;
  assign start_word = host_word && (host_sel == SEL_DATA);

  nand_cfg_reg #(.SETUP_W(SETUP_W), .CFG_W(CFG_W)) u_cfg (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (cfg_wr),
    .wr_setup   (host_wdata[8 +: SETUP_W]),
    .wr_strobe  (host_wdata[6:4]),
    .wr_hold    (host_wdata[2:0]),
    .wr_ce_off  (host_wdata[CFG_W-1]),
    .setup_len  (setup_len),
    .strobe_len (strobe_len),
    .hold_len   (hold_len),
    .ce_off     (ce_off),
    .cfg_q      (cfg_q)
  );

  nand_phase_seq #(.SETUP_W(SETUP_W), .LANES(LANES)) u_phase (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .multi_in    (start_word),
    .setup_len   (setup_len),
    .strobe_len  (strobe_len),
    .hold_len    (hold_len),
    .phase       (phase),
    .lane        (lane),
    .strobe_last (strobe_last),
    .xfer_done   (xfer_done)
  );

  nand_rb_sync #(.STAGES(SYNC_STAGES)) u_rb (
    .clk    (clk),
    .rst    (rst),
    .rb_pin (nand_rb),
    .ready  (dev_ready)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      op_sel   <= SEL_CMD;
      op_read  <= 1'b0;
      op_data  <= '0;
      rd_buf   <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= 1'b0;
      if (start) begin
        op_sel  <= host_sel;
        op_read <= op_rd;
        op_data <= host_wdata;
        rd_buf  <= '0;
      end
      if (strobe_last && op_read)
        rd_buf[lane*BYTE_W +: BYTE_W] <= nand_dq_i;
      if (xfer_done && op_read) begin
        rd_valid <= 1'b1;
        rd_data  <= rd_buf;
      end
    end
  end

  assign host_busy  = !idle;
  assign nand_ce_n  = ce_off;
  assign nand_cle   = !idle && (op_sel == SEL_CMD);
  assign nand_ale   = !idle && (op_sel == SEL_ADDR);
  assign nand_we_n  = !((phase == PH_STROBE) && !op_read);
  assign nand_re_n  = !((phase == PH_STROBE) && op_read);
  assign nand_dq_o  = op_data[lane*BYTE_W +: BYTE_W];
  assign nand_dq_oe = !idle && !op_read;

  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(!nand_we_n && !nand_re_n));
  // R10
  latch_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(nand_cle && nand_ale));
  // R8
  cfg_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (host_busy && host_wr) |=> $stable(cfg_q));
  // R6
  rd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);
  // R3
  hold_after_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(nand_we_n) |-> host_busy);
  // R11
  read_bus_off_chk: assert property (@(posedge clk) disable iff (rst)
    !nand_re_n |-> !nand_dq_oe);
endmodule

// File: tb/nand_cycle_seq_bench.sv
module nand_cycle_seq_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr = 1'b0, host_rd = 1'b0, host_word = 1'b0;
  logic [1:0]  host_sel = 2'd0;
  logic [31:0] host_wdata = '0;
  logic        host_busy, rd_valid, dev_ready;
  logic [31:0] rd_data;
  logic [15:0] cfg_q;
  logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic [7:0]  nand_dq_o, nand_dq_i;
  logic        nand_rb = 1'b1;

  int errors = 0;
  int checks = 0;
  logic [7:0] rd_bytes [4];
  int rd_idx = 0;

  always #4 clk = ~clk;

  assign nand_dq_i = rd_bytes[rd_idx % 4];
  always @(posedge nand_re_n) rd_idx <= rd_idx + 1;

  nand_cycle_seq u_nand_cycle_seq (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_sel(host_sel), .host_word(host_word), .host_wdata(host_wdata),
    .host_busy(host_busy), .rd_valid(rd_valid), .rd_data(rd_data),
    .cfg_q(cfg_q), .dev_ready(dev_ready), .nand_ce_n(nand_ce_n),
    .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
    .nand_re_n(nand_re_n), .nand_dq_o(nand_dq_o), .nand_dq_oe(nand_dq_oe),
    .nand_dq_i(nand_dq_i), .nand_rb(nand_rb)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] cfg_word(int s, int t, int h, int ce);
    return 16'((ce << 15) | (s << 8) | (t << 4) | h);
  endfunction

  task automatic write_cfg(int s, int t, int h, int ce);
    @(negedge clk);
    host_wr = 1; host_sel = 2'd0; host_wdata = 32'(cfg_word(s, t, h, ce));
    @(negedge clk);
    host_wr = 0;
  endtask

  // Runs one transfer and compares every busy cycle against the phase model.
  task automatic run_op(input string req, input logic [1:0] sel, input logic word,
                        input logic rd, input logic [31:0] data,
                        input int s, input int t, input int h);
    int nb, len, n, bad, b, p;
    logic low, dv;
    nb  = (word && sel == 2'd3) ? 4 : 1;
    len = s + t + h + 3;
    rd_idx = 0;
    @(negedge clk);
    host_sel = sel; host_word = word; host_wdata = data;
    host_wr = !rd; host_rd = rd;
    @(negedge clk);
    host_wr = 0; host_rd = 0;
    n = 0; bad = 0;
    while (host_busy && n < 200) begin
      b = n / len; p = n % len;
      low = (p >= s + 1) && (p < s + t + 2);
      if (nand_we_n !== !(low && !rd)) bad++;
      if (nand_re_n !== !(low && rd)) bad++;
      if (nand_cle !== (sel == 2'd1)) bad++;
      if (nand_ale !== (sel == 2'd2)) bad++;
      if (nand_dq_oe !== !rd) bad++;
      dv = 1'b1;
      if (!rd && nand_dq_o !== data[b*8 +: 8]) dv = 1'b0;
      if (!dv) bad++;
      n++;
      @(negedge clk);
    end
    check({req, " R3 waveform mismatches"}, 32'(bad), 32'd0);
    check("R3 busy length", 32'(n), 32'(nb * len));
    if (rd) begin
      check("R6 rd_valid", 32'(rd_valid), 32'd1);
      check("R6 rd_data", rd_data,
            nb == 4 ? {rd_bytes[3], rd_bytes[2], rd_bytes[1], rd_bytes[0]}
                    : {24'd0, rd_bytes[0]});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rd_bytes[0] = 8'hA1; rd_bytes[1] = 8'hB2; rd_bytes[2] = 8'hC3; rd_bytes[3] = 8'hD4;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1 cfg_q", 32'(cfg_q), 32'h8377);
    check("R1 ce_n", 32'(nand_ce_n), 32'd1);
    check("R1 strobes", {30'd0, nand_we_n, nand_re_n}, 32'd3);
    check("R1 busy/oe", {30'd0, host_busy, nand_dq_oe}, 32'd0);

    // R3 R4 with reset timing, command then address (word flag ignored)
    run_op("R4 cmd default", 2'd1, 1'b0, 1'b0, 32'h0000_0070, 3, 7, 7);
    run_op("R4 addr word-ignored", 2'd2, 1'b1, 1'b0, 32'h1234_5600, 3, 7, 7);

    // R2 R3 exhaustive sweep of timing fields with command cycles
    for (int s = 0; s < 4; s++)
      for (int t = 0; t < 8; t++)
        for (int h = 0; h < 8; h++) begin
          write_cfg(s, t, h, 1);
          check("R2 cfg readback", 32'(cfg_q), 32'(cfg_word(s, t, h, 1)));
          run_op("R4 cmd sweep", 2'd1, 1'b0, 1'b0, 32'(s * 64 + t * 8 + h), s, t, h);
        end

    // R5 data word and byte writes, several patterns and timings
    write_cfg(0, 0, 0, 0);
    run_op("R5 word min", 2'd3, 1'b1, 1'b0, 32'hDEAD_BEEF, 0, 0, 0);
    run_op("R5 byte min", 2'd3, 1'b0, 1'b0, 32'hFFFF_FF5A, 0, 0, 0);
    write_cfg(2, 5, 1, 0);
    run_op("R5 word mid", 2'd3, 1'b1, 1'b0, 32'h0102_0304, 2, 5, 1);
    run_op("R4 addr mid", 2'd2, 1'b0, 1'b0, 32'h0000_00C3, 2, 5, 1);

    // R7 chip enable follows config bit
    check("R7 ce_n low", 32'(nand_ce_n), 32'd0);

    // R6 reads
    run_op("R6 word read", 2'd3, 1'b1, 1'b1, 32'h0, 2, 5, 1);
    @(negedge clk);
    check("R6 rd_valid single", 32'(rd_valid), 32'd0);
    write_cfg(1, 2, 3, 1);
    check("R7 ce_n high", 32'(nand_ce_n), 32'd1);
    rd_bytes[0] = 8'h3C;
    run_op("R6 byte read", 2'd3, 1'b0, 1'b1, 32'h0, 1, 2, 3);

    // R8 requests during busy are ignored
    write_cfg(3, 7, 7, 1);
    @(negedge clk);
    host_wr = 1; host_sel = 2'd1; host_wdata = 32'h90;
    @(negedge clk);
    host_wr = 1; host_sel = 2'd0; host_wdata = 32'h0000_0000;
    repeat (3) @(negedge clk);
    host_wr = 1; host_sel = 2'd2;
    @(negedge clk);
    host_wr = 0;
    check("R8 cfg unchanged", 32'(cfg_q), 32'(cfg_word(3, 7, 7, 1)));
    while (host_busy) @(negedge clk);
    repeat (3) @(negedge clk);
    check("R8 no extra cycle", {31'd0, host_busy}, 32'd0);
    check("R8 cfg unchanged after", 32'(cfg_q), 32'(cfg_word(3, 7, 7, 1)));

    // R9 ready synchroniser
    check("R9 ready initial", 32'(dev_ready), 32'd1);
    nand_rb = 0;
    @(negedge clk);
    check("R9 ready one edge", 32'(dev_ready), 32'd1);
    @(negedge clk);
    check("R9 ready two edges", 32'(dev_ready), 32'd0);
    nand_rb = 1;
    @(negedge clk);
    @(negedge clk);
    check("R9 ready back", 32'(dev_ready), 32'd1);

    // R10 R11 idle levels
    check("R10 idle strobes", {30'd0, nand_we_n, nand_re_n}, 32'd3);
    check("R11 idle oe", 32'(nand_dq_oe), 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule